// File: doc/BRIEF.md
# Paired Register File Access Unit

This block is the general register file of a 32-bit core: 32 registers of 32 bits each, extended so that double-precision instructions can treat two 32-bit registers as one 64-bit value. An instruction word enters combinationally. The unit does three things with it:

- It recognises the double-precision operations.
- It works out each register pair from a base index and a per-operand offset bit, and rejects any pair that would run past the last register.
- It presents up to three assembled 64-bit operands to an external floating-point datapath.

When that datapath returns a 64-bit result with a valid strobe, the unit splits it back into two registers and writes both halves on the same clock edge.

Ordinary single-register traffic uses a separate 32-bit read port and a separate 32-bit write port. The double-precision path is gated by a configuration input that says whether the 64-bit-on-32-bit float extension is present. Reads are combinational. Writes happen on the rising edge. A synchronous reset clears every register.

Top module: `pair_rf_unit`

## Requirements
- R1: A word is a double operation (`dp_op`=1) when bits 31:26 equal 6'h32 and bits 7:0 hold one of these codes: 8'h10, 8'h11, 8'h12, 8'h13 or 8'h16 (three-pair arithmetic); 8'h17 (multiply-add); 8'h14 or 8'h15 (two-pair conversion); 8'h18 to 8'h1D (compare); 8'h34 (single to double); 8'h35 (double to single). For any other word `dp_op`=0, `illegal`=0, and `res_valid` changes no register.
- R2: Fields are d = bits 25:21, a = bits 20:16, b = bits 15:11. The offset bits are pd = bit 10, pa = bit 9 and pb = bit 8. A pair built from index r and offset p is {R[r], R[r+1+p]}, with the upper half first. `opa` is pair (a,pa), `opb` is pair (b,pb), and `opc` is pair (d,pd), which is the accumulator for multiply-add.
- R3: A pair is legal only when r+1+p < 32. A double operation is illegal when any pair it uses is illegal. Pairs in use: arithmetic and multiply-add use d, a and b; conversion uses d and a; compare uses a and b; single to double uses d; double to single uses a. Fields that an operation does not use as pairs are not checked.
- R4: When `dbl_en`=0, every double operation has `illegal`=1 and writes nothing.
- R5: When `res_valid`=1 and a legal operation writes a pair, R[d] takes `res_data[63:32]` and R[d+1+pd] takes `res_data[31:0]`. Both halves are written on the same edge.
- R6: Single to double presents the plain register R[a] on `sgl_a` and writes a pair. Double to single writes only R[d], taking `res_data[31:0]`.
- R7: Compare operations write no register, even when `res_valid`=1.
- R8: Register 0 always reads 0. Any write aimed at index 0 is dropped, while the other half of the same pair write still lands.
- R9: An illegal operation writes no register, even when `res_valid`=1.
- R10: `rd_data` is R[`rd_addr`], read combinationally. `wr_en` writes `wr_data` into R[`wr_addr`] on the edge. If a pair or result write hits the same index on the same edge, the result write wins.
- R11: A synchronous reset (`rst`=1) clears all registers, and it overrides any write in that cycle.
- R12: An operand output whose pair is illegal reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbl_en | input | 1 | Enables the double-precision path |
| insn | input | 32 | Instruction word |
| dp_op | output | 1 | The word is a double operation |
| illegal | output | 1 | A double operation is rejected |
| opa | output | 64 | Operand pair A |
| opb | output | 64 | Operand pair B |
| opc | output | 64 | Destination pair, used as the accumulator |
| sgl_a | output | 32 | Plain register A, for single to double |
| res_valid | input | 1 | Result strobe |
| res_data | input | 64 | Result from the datapath |
| rd_addr | input | 5 | Single read index |
| rd_data | output | 32 | Single read data |
| wr_en | input | 1 | Single write enable |
| wr_addr | input | 5 | Single write index |
| wr_data | input | 32 | Single write data |

## Verification
The hardest cases to reach are at the top edge of the register file:

- A pair whose base is 30 with the offset bit set, which is rejected.
- A pair whose base is 30 with the offset bit clear, which is accepted.
- The same edge cases sitting in a field that the operation does not use as a pair, such as the destination of a compare or the source of single to double, which are accepted.

Uniform random indices hit these cases rarely. The stimulus therefore biases every index toward 30 and 31 for a quarter of the draws, and also runs directed words for each of the edge cases. Two further cases need a same-cycle collision: a single write and a pair write to the same register in one cycle, and a pair write whose upper half targets register 0. Both are set up on purpose and then read back through the single port.

// File: rtl/pair_rf_pkg.sv
`timescale 1ns/1ps
package pair_rf_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);

    // instruction field positions (fixed by the encoding)
    localparam int POS_D   = 21;
    localparam int POS_A   = 16;
    localparam int POS_B   = 11;
    localparam int POS_PD  = 10;
    localparam int POS_PA  = 9;
    localparam int POS_PB  = 8;
    localparam logic [5:0] MAJOR_FP = 6'h32;

    typedef enum logic [2:0] {
        K_NONE,
        K_ARITH3,
        K_MADD,
        K_CONV2,
        K_CMP,
        K_S2D,
        K_D2S
    } dkind_e;
endpackage

// File: rtl/pair_rf_decode.sv
`timescale 1ns/1ps
module pair_rf_decode
    import pair_rf_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   insn_i,
    input  logic            dbl_en_i,
    output dkind_e          kind_o,
    output logic [RIDX-1:0] base_o [3],   // 0:a 1:b 2:d
    output logic [RIDX-1:0] part_o [3],
    output logic [2:0]      ok_o,
    output logic            dp_op_o,
    output logic            illegal_o,
    output logic            wr_pair_o,
    output logic            wr_single_o
);
    logic [2:0] off;
    logic [2:0] use_pair;

    assign base_o[0] = insn_i[POS_A +: RIDX];
    assign base_o[1] = insn_i[POS_B +: RIDX];
    assign base_o[2] = insn_i[POS_D +: RIDX];
    assign off = {insn_i[POS_PD], insn_i[POS_PB], insn_i[POS_PA]};

    // partner index and legality, one per operand
    for (genvar g = 0; g < 3; g++) begin : g_pair
        logic [RIDX:0] sum;
        assign sum      = {1'b0, base_o[g]} + (RIDX+1)'(1) + {{RIDX{1'b0}}, off[g]};
        assign ok_o[g]  = (sum < (RIDX+1)'(NREG));
        assign part_o[g] = sum[RIDX-1:0];
    end

    always_comb begin
        kind_o = K_NONE;
        if (insn_i[31:26] == MAJOR_FP) begin
            case (insn_i[7:0])
                8'h10, 8'h11, 8'h12, 8'h13, 8'h16: kind_o = K_ARITH3;
                8'h17:                             kind_o = K_MADD;
                8'h14, 8'h15:                      kind_o = K_CONV2;
                8'h18, 8'h19, 8'h1A,
                8'h1B, 8'h1C, 8'h1D:               kind_o = K_CMP;
                8'h34:                             kind_o = K_S2D;
                8'h35:                             kind_o = K_D2S;
                default:                           kind_o = K_NONE;
            endcase
        end
    end

    always_comb begin
        use_pair = 3'b000;
        case (kind_o)
            K_ARITH3, K_MADD: use_pair = 3'b111;
            K_CONV2:          use_pair = 3'b101;
            K_CMP:            use_pair = 3'b011;
            K_S2D:            use_pair = 3'b100;
            K_D2S:            use_pair = 3'b001;
            default:          use_pair = 3'b000;
        endcase
    end

    assign dp_op_o     = (kind_o != K_NONE);
    assign illegal_o   = dp_op_o && (!dbl_en_i || |(use_pair & ~ok_o));
    assign wr_pair_o   = dp_op_o && !illegal_o && use_pair[2];
    assign wr_single_o = (kind_o == K_D2S) && !illegal_o;

    AST_PARTNER_ABOVE: assert property (@(posedge clk) disable iff (rst)
        wr_pair_o |-> (part_o[2] > base_o[2])) else $error("partner below base"); // R3
endmodule

// File: rtl/pair_rf_regs.sv
`timescale 1ns/1ps
module pair_rf_regs #(
    parameter int XW  = 32,
    parameter int NR  = 32,
    parameter int NRD = 7,
    localparam int AW = $clog2(NR)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NRD-1:0][AW-1:0]  raddr_i,
    output logic [NRD-1:0][XW-1:0]  rdata_o,
    input  logic                    hi_we_i,
    input  logic [AW-1:0]           hi_idx_i,
    input  logic [XW-1:0]           hi_data_i,
    input  logic                    lo_we_i,
    input  logic [AW-1:0]           lo_idx_i,
    input  logic [XW-1:0]           lo_data_i,
    input  logic                    sg_we_i,
    input  logic [AW-1:0]           sg_idx_i,
    input  logic [XW-1:0]           sg_data_i
);
    typedef struct packed {
        logic [NR-1:0][XW-1:0] rf;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sg_we_i) st_d.rf[sg_idx_i] = sg_data_i;
        if (lo_we_i) st_d.rf[lo_idx_i] = lo_data_i;
        if (hi_we_i) st_d.rf[hi_idx_i] = hi_data_i;
        st_d.rf[0] = '0;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata_o[g] = st_q.rf[raddr_i[g]];
    end

    AST_R0_HELD: assert property (@(posedge clk) disable iff (rst)
        st_q.rf[0] == '0) else $error("r0 nonzero"); // R8

    AST_PAIR_BOTH: assert property (@(posedge clk) disable iff (rst)
        (hi_we_i && lo_we_i && hi_idx_i != '0 && hi_idx_i != lo_idx_i) |=>
        (st_q.rf[$past(hi_idx_i)] == $past(hi_data_i) &&
         st_q.rf[$past(lo_idx_i)] == $past(lo_data_i))) else $error("pair torn"); // R5
endmodule

// File: rtl/pair_rf_unit.sv
`timescale 1ns/1ps
module pair_rf_unit
    import pair_rf_pkg::*;
#(
    parameter int XW = XLEN,
    localparam int DW = 2 * XW,
    localparam int NRD = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dbl_en,
    input  logic [31:0]     insn,
    output logic            dp_op,
    output logic            illegal,
    output logic [DW-1:0]   opa,
    output logic [DW-1:0]   opb,
    output logic [DW-1:0]   opc,
    output logic [XW-1:0]   sgl_a,
    input  logic            res_valid,
    input  logic [DW-1:0]   res_data,
    input  logic [RIDX-1:0] rd_addr,
    output logic [XW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [RIDX-1:0] wr_addr,
    input  logic [XW-1:0]   wr_data
);
    dkind_e                  kind;
    logic [RIDX-1:0]         base [3];
    logic [RIDX-1:0]         part [3];
    logic [2:0]              ok;
    logic                    wr_pair, wr_single;
    logic [NRD-1:0][RIDX-1:0] raddr;
    logic [NRD-1:0][XW-1:0]   rdata;
    logic                    hi_we, lo_we;
    logic [XW-1:0]           hi_data;

    pair_rf_decode #(.IW(32)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .insn_i      (insn),
        .dbl_en_i    (dbl_en),
        .kind_o      (kind),
        .base_o      (base),
        .part_o      (part),
        .ok_o        (ok),
        .dp_op_o     (dp_op),
        .illegal_o   (illegal),
        .wr_pair_o   (wr_pair),
        .wr_single_o (wr_single)
    );

    // read port map: a, a partner, b, b partner, d, d partner, single
    assign raddr[0] = base[0];
    assign raddr[1] = part[0];
    assign raddr[2] = base[1];
    assign raddr[3] = part[1];
    assign raddr[4] = base[2];
    assign raddr[5] = part[2];
    assign raddr[6] = rd_addr;

    assign hi_we   = res_valid && (wr_pair || wr_single);
    assign lo_we   = res_valid && wr_pair;
    assign hi_data = wr_single ? res_data[XW-1:0] : res_data[DW-1:XW];

    pair_rf_regs #(.XW(XW), .NR(NREG), .NRD(NRD)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .raddr_i   (raddr),
        .rdata_o   (rdata),
        .hi_we_i   (hi_we),
        .hi_idx_i  (base[2]),
        .hi_data_i (hi_data),
        .lo_we_i   (lo_we),
        .lo_idx_i  (part[2]),
        .lo_data_i (res_data[XW-1:0]),
        .sg_we_i   (wr_en),
        .sg_idx_i  (wr_addr),
        .sg_data_i (wr_data)
    );

    assign opa     = ok[0] ? {rdata[0], rdata[1]} : '0;
    assign opb     = ok[1] ? {rdata[2], rdata[3]} : '0;
    assign opc     = ok[2] ? {rdata[4], rdata[5]} : '0;
    assign sgl_a   = rdata[0];
    assign rd_data = rdata[6];

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(hi_we || lo_we)) else $error("illegal op wrote"); // R9

    AST_DISABLED_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (dp_op && !dbl_en) |-> (illegal && !hi_we)) else $error("path not gated"); // R4

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (kind == K_CMP) |-> !(hi_we || lo_we)) else $error("compare wrote"); // R7

    AST_OTHER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !dp_op |-> !(hi_we || lo_we)) else $error("non-double op wrote"); // R1
endmodule

// File: tb/pair_rf_unit_tb.sv
`timescale 1ns/1ps
module pair_rf_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbl_en = 1'b0;
    logic [31:0] insn = '0;
    logic        dp_op, illegal;
    logic [63:0] opa, opb, opc;
    logic [31:0] sgl_a;
    logic        res_valid = 1'b0;
    logic [63:0] res_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    logic [31:0] m [32];
    logic [7:0] subs [16] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h16, 8'h17, 8'h14, 8'h15,
                              8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h34, 8'h35};

    always #2.5 clk = ~clk;

    pair_rf_unit u_dut (
        .clk(clk), .rst(rst), .dbl_en(dbl_en), .insn(insn),
        .dp_op(dp_op), .illegal(illegal), .opa(opa), .opb(opb), .opc(opc),
        .sgl_a(sgl_a), .res_valid(res_valid), .res_data(res_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [31:0] mk(input logic [7:0] sub, input int d, input int a,
                                       input int b, input bit pd, input bit pa, input bit pb);
        return {6'h32, 5'(d), 5'(a), 5'(b), pd, pa, pb, sub};
    endfunction

    function automatic int kind_of(input logic [31:0] w);
        if (w[31:26] != 6'h32) return 0;
        case (w[7:0])
            8'h10, 8'h11, 8'h12, 8'h13, 8'h16: return 1;
            8'h17: return 2;
            8'h14, 8'h15: return 3;
            8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D: return 4;
            8'h34: return 5;
            8'h35: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] pairv(input int r, input int p);
        if (r + 1 + p >= 32) return 64'h0;
        return {m[r], m[r+1+p]};
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] w, input bit en, input bit rv, input logic [63:0] res,
                        input int ra, input bit we, input int wa, input logic [31:0] wd,
                        input string tag);
        int k, d, a, b;
        bit pd, pa, pb, ua, ub, ud, ill, dp;
        @(negedge clk);
        insn = w; dbl_en = en; res_valid = rv; res_data = res;
        rd_addr = 5'(ra); wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        #1;
        k = kind_of(w);
        d = int'(w[25:21]); a = int'(w[20:16]); b = int'(w[15:11]);
        pd = w[10]; pa = w[9]; pb = w[8];
        ua = (k == 1 || k == 2 || k == 3 || k == 4 || k == 6);
        ub = (k == 1 || k == 2 || k == 4);
        ud = (k == 1 || k == 2 || k == 3 || k == 5);
        dp = (k != 0);
        ill = dp && (!en || (ua && a + 1 + pa >= 32) || (ub && b + 1 + pb >= 32)
                         || (ud && d + 1 + pd >= 32));
        chk({63'h0, dp_op}, {63'h0, dp}, {"R1 dp_op ", tag});
        chk({63'h0, illegal}, {63'h0, ill}, {"R3 R4 illegal ", tag});
        chk(opa, pairv(a, int'(pa)), {"R2 R12 opa ", tag});
        chk(opb, pairv(b, int'(pb)), {"R2 R12 opb ", tag});
        chk(opc, pairv(d, int'(pd)), {"R2 R12 opc ", tag});
        chk({32'h0, sgl_a}, {32'h0, m[a]}, {"R6 sgl_a ", tag});
        chk({32'h0, rd_data}, {32'h0, m[ra]}, {"R10 rd_data ", tag});
        // model the coming edge
        if (we && wa != 0) m[wa] = wd;
        if (rv && !ill) begin
            if (ud) begin
                m[d+1+pd] = res[31:0];
                if (d != 0) m[d] = res[63:32];
            end else if (k == 6) begin
                if (d != 0) m[d] = res[31:0];
            end
        end
    endtask

    task automatic peek(input int ra, input string tag);
        step(32'h0, 1'b1, 1'b0, 64'h0, ra, 1'b0, 0, 32'h0, tag);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd5; wr_data = '1;
        insn = mk(8'h10, 2, 4, 6, 0, 0, 0); dbl_en = 1'b1; res_valid = 1'b1; res_data = '1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; res_valid = 1'b0; insn = '0;
        for (int i = 0; i < 32; i++) m[i] = '0;
    endtask

    function automatic int pick();
        if ($urandom % 4 == 0) return 30 + int'($urandom % 2);
        return int'($urandom % 32);
    endfunction

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        for (int i = 0; i < 32; i++) peek(i, "R11 after reset");
        // R10: fill through single port
        for (int i = 0; i < 32; i++)
            step(32'h0, 1'b1, 1'b0, 64'h0, 0, 1'b1, i, 32'hC000_0000 | (i << 8) | i, "R10 fill");
        peek(0, "R8 write to r0 dropped");
        peek(17, "R10 readback");
        // R2 R5: arithmetic pair op
        step(mk(8'h10, 2, 4, 6, 0, 1, 0), 1, 1, 64'h1111_2222_3333_4444, 0, 0, 0, 0, "R5 add");
        peek(2, "R5 upper half"); peek(3, "R5 lower half");
        // R2: multiply-add accumulator from d pair
        step(mk(8'h17, 8, 10, 12, 1, 0, 1), 1, 1, 64'hAAAA_0001_BBBB_0002, 0, 0, 0, 0, "R2 madd");
        peek(8, "R5 madd hi"); peek(10, "R5 madd lo"); peek(9, "R5 madd skip");
        // R3 R9: boundary illegal pairs
        step(mk(8'h11, 14, 31, 6, 0, 0, 0), 1, 1, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 0, "R3 a=31");
        step(mk(8'h12, 14, 4, 30, 0, 0, 1), 1, 1, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 0, "R3 b=30 p=1");
        step(mk(8'h14, 30, 4, 0, 1, 0, 0), 1, 1, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 0, "R9 d=30 p=1");
        peek(14, "R9 no write"); peek(30, "R9 no write");
        step(mk(8'h15, 30, 30, 0, 0, 0, 0), 1, 1, 64'h5555_6666_7777_8888, 0, 0, 0, 0, "R3 base 30 legal");
        peek(30, "R5 boundary hi"); peek(31, "R5 boundary lo");
        // R4: path disabled
        step(mk(8'h10, 20, 4, 6, 0, 0, 0), 0, 1, 64'h9999_9999_9999_9999, 0, 0, 0, 0, "R4 disabled");
        peek(20, "R4 no write");
        // R6: single to double (a=31 plain, legal) and double to single
        step(mk(8'h34, 22, 31, 0, 1, 0, 0), 1, 1, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, "R6 s2d");
        peek(22, "R6 s2d hi"); peek(24, "R6 s2d lo");
        step(mk(8'h35, 31, 4, 0, 0, 0, 0), 1, 1, 64'hFFFF_0000_1234_5678, 0, 0, 0, 0, "R6 d2s");
        peek(31, "R6 d2s single"); peek(0, "R6 r0");
        // R7: compare with out-of-range d field, no write
        step(mk(8'h1A, 31, 4, 6, 1, 0, 0), 1, 1, 64'h7777_7777_7777_7777, 0, 0, 0, 0, "R7 compare");
        peek(31, "R7 no write"); peek(4, "R7 no write");
        // R8: pair write whose upper half targets r0
        step(mk(8'h13, 0, 4, 6, 1, 0, 0), 1, 1, 64'hCAFE_CAFE_0BAD_F00D, 0, 0, 0, 0, "R8 d=0");
        peek(0, "R8 r0 stays zero"); peek(2, "R8 lower half lands");
        // R10: collision, result write wins
        step(mk(8'h16, 12, 4, 6, 0, 0, 0), 1, 1, 64'h1212_1212_1313_1313, 0, 1, 13, 32'hBAD0_BAD0, "R10 collide");
        peek(13, "R10 result wins"); peek(12, "R10 hi");
        // R1: non-double word with result valid
        step({6'h31, 5'd6, 5'd4, 5'd6, 3'b000, 8'h10}, 1, 1, 64'h4444_4444_4444_4444, 6, 0, 0, 0, "R1 other major");
        step(mk(8'h20, 6, 4, 6, 0, 0, 0), 1, 1, 64'h4444_4444_4444_4444, 6, 0, 0, 0, "R1 other sub");
        peek(6, "R1 no write"); peek(7, "R1 no write");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] w;
            if ($urandom % 8 == 0) w = $urandom;
            else w = mk(subs[$urandom % 16], pick(), pick(), pick(),
                        1'($urandom), 1'($urandom), 1'($urandom));
            step(w, ($urandom % 10) != 0, ($urandom % 10) < 7, {$urandom, $urandom},
                 int'($urandom % 32), ($urandom % 10) < 3, pick(), $urandom, "random");
        end
        // R11: reset in the middle of traffic
        do_reset();
        for (int i = 0; i < 32; i++) peek(i, "R11 mid reset");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end
endmodule